// File: doc/BRIEF.md
# DLL Delay Code Stepper

This block keeps the composite delay setting of one byte lane. The setting has four fields: a 1-bit coarse field, a 2-bit clock-delay field, a 4-bit tap field and a 3-bit phase-interpolator (phase) field. A training sequencer walks the setting one unit at a time with a step-up or step-down pulse. The code behaves as a mixed-radix counter. The phase field counts 0 to 6. The tap range depends on the memory-clock select. Moving past the clock-delay limit trades one clock-delay unit for one coarse unit. After each accepted step or load, the block derives two dead-band control bits from the tap and phase values against two thresholds that belong to the current clock setting.

A step is accepted in the cycle the pulse is sampled. The new code, the new dead-band bits and a one-cycle done strobe appear right after that clock edge. A step past the top of the range, or below zero, is refused. The code stays as it was, and an error flag rises together with the done strobe. A load port writes a starting code and has priority over any step that arrives in the same cycle.

Control is a four-state machine:

- ST_IDLE: no done, no error.
- ST_STEPPED: done strobe.
- ST_REFUSED: done strobe with error.
- ST_FAULT: error held.

The transitions are:

- Load goes to ST_IDLE from any state.
- An accepted step goes to ST_STEPPED.
- A refused step goes to ST_REFUSED.
- With no step, ST_STEPPED falls to ST_IDLE and ST_REFUSED falls to ST_FAULT.
- Otherwise ST_IDLE and ST_FAULT hold.

Top module: `dll_code_stepper`

## Requirements
- R1: While reset (rst_n low, asynchronous) is active and directly after it, every code field is 0, db_en_o=1, db_sel_o=1, done_o=0 and err_o=0.
- R2: A step up with phase below 6 increments phase and leaves the other fields unchanged. A step down with phase above 0 decrements phase and leaves the other fields unchanged.
- R3: The tap top is set by clk_sel_i: 2'b00 gives 12, 2'b01 gives 10, 2'b10 gives 13, and 2'b11 behaves as 2'b00. A step up at phase 6 with tap below the tap top clears phase and increments tap.
- R4: A step up at phase 6 with tap at or above the tap top behaves as follows. If clock-delay is below 2, it clears tap and phase and increments clock-delay. Otherwise, if coarse is 0, it clears tap and phase, decrements clock-delay and sets coarse to 1. Starting from all zeros, the last good code is reached after 5*(tap top+1)*7-1 steps.
- R5: A step down works in mirror. At phase 0 with tap above 0, it sets phase to 6 and decrements tap. At tap 0 and phase 0, it loads tap with the tap top and phase with 6, and then either decrements a nonzero clock-delay, or, if clock-delay is 0 and coarse is 1, increments clock-delay and clears coarse.
- R6: A step up at the last code (coarse 1, clock-delay 2, tap at or above the top, phase 6), or a step down at all zeros, leaves the code and the dead-band bits unchanged. It gives done_o=1 with err_o=1. err_o then stays 1 until the next load or accepted step.
- R7: With thresholds (t0,p0) and (t1,p1) of (3,2)/(10,3) at 2'b00, (2,6)/(8,7) at 2'b01 and (3,6)/(11,4) at 2'b10, the dead-band bits are set as follows. They are en=1 and sel=1 when tap<t0, or when tap=t0 and phase<p0. Otherwise they are en=0 and sel=0 when tap<t1, or when tap=t1 and phase<p1. Otherwise they are en=1 and sel=0.
- R8: An accepted or refused step produces done_o=1 in the cycle after the pulse is sampled, with the new code already visible. done_o is 0 in any cycle that follows no step.
- R9: load_i writes all four fields and recomputes the dead-band bits from the loaded code. It gives done_o=0 and err_o=0, and it overrides a step pulse sampled in the same cycle.
- R10: Step-up and step-down sampled high together, without a load, are ignored: the code, the dead-band bits and err_o keep their values and done_o is 0.
- R11: A change of clk_sel_i alone does not alter the code or the dead-band bits. The new setting applies from the next step or load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel_i | input | 2 | Memory-clock setting select |
| step_up_i | input | 1 | Request one unit later |
| step_dn_i | input | 1 | Request one unit earlier |
| load_i | input | 1 | Write the load fields into the code |
| load_coarse_i | input | 1 | Coarse value to load |
| load_cdly_i | input | 2 | Clock-delay value to load |
| load_tap_i | input | 4 | Tap value to load |
| load_pi_i | input | 3 | Phase value to load |
| coarse_o | output | 1 | Current coarse field |
| cdly_o | output | 2 | Current clock-delay field |
| tap_o | output | 4 | Current tap field |
| pi_o | output | 3 | Current phase field |
| db_en_o | output | 1 | Dead-band enable |
| db_sel_o | output | 1 | Dead-band select |
| done_o | output | 1 | One-cycle strobe after each step request |
| err_o | output | 1 | Overflow or underflow of the last step |

## Verification
The two functions that can fall in the same cycle are a load and a step. The bench drives load_i together with step_up_i, both in directed cases and in random cases. It then expects the loaded code with done_o low and err_o cleared, rather than a step applied on top of the load. The two step directions can also collide. That case is provoked with both pulses high at once and judged by an unchanged code, unchanged dead-band bits, an unchanged err_o and a low done_o.

// File: rtl/dls_pkg.sv
package dls_pkg;

    localparam int CO_W  = 1;
    localparam int CD_W  = 2;
    localparam int TAP_W = 4;
    localparam int PI_W  = 3;

    typedef struct packed {
        logic [CO_W-1:0]  co;
        logic [CD_W-1:0]  cd;
        logic [TAP_W-1:0] tap;
        logic [PI_W-1:0]  pi;
    } dly_code_t;

    typedef struct packed {
        logic [TAP_W-1:0] tap_top;
        logic [TAP_W-1:0] t0;
        logic [PI_W-1:0]  p0;
        logic [TAP_W-1:0] t1;
        logic [PI_W-1:0]  p1;
    } spd_lim_t;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_STEPPED = 2'd1,
        ST_REFUSED = 2'd2,
        ST_FAULT   = 2'd3
    } stp_state_t;

endpackage

// File: rtl/dls_speed_table.sv
module dls_speed_table
    import dls_pkg::*;
(
    input  logic [1:0] sel_i,
    output spd_lim_t   lim_o
);

    // Per clock setting: tap top and both dead-band thresholds.
    // The spare select value falls back to the slowest setting.
    always_comb begin
        unique case (sel_i)
            2'd1: begin
                lim_o.tap_top = TAP_W'(10);
                lim_o.t0      = TAP_W'(2);
                lim_o.p0      = PI_W'(6);
                lim_o.t1      = TAP_W'(8);
                lim_o.p1      = PI_W'(7);
            end
            2'd2: begin
                lim_o.tap_top = TAP_W'(13);
                lim_o.t0      = TAP_W'(3);
                lim_o.p0      = PI_W'(6);
                lim_o.t1      = TAP_W'(11);
                lim_o.p1      = PI_W'(4);
            end
            default: begin
                lim_o.tap_top = TAP_W'(12);
                lim_o.t0      = TAP_W'(3);
                lim_o.p0      = PI_W'(2);
                lim_o.t1      = TAP_W'(10);
                lim_o.p1      = PI_W'(3);
            end
        endcase
    end

endmodule

// File: rtl/dls_next_code.sv
module dls_next_code
    import dls_pkg::*;
#(
    parameter int PI_TOP = 6,
    parameter int CD_TOP = 2,
    parameter int CO_TOP = 1
) (
    input  dly_code_t        cur_i,
    input  logic [TAP_W-1:0] tap_top_i,
    output dly_code_t        up_o,
    output logic             up_ok_o,
    output dly_code_t        dn_o,
    output logic             dn_ok_o
);

    localparam logic [PI_W-1:0] PI_LIM = PI_W'(PI_TOP);
    localparam logic [CD_W-1:0] CD_LIM = CD_W'(CD_TOP);
    localparam logic [CO_W-1:0] CO_LIM = CO_W'(CO_TOP);

    // Later by one unit: phase, then tap, then clock-delay, then coarse
    // (the coarse carry hands one clock-delay unit back).
    always_comb begin
        up_o    = cur_i;
        up_ok_o = 1'b1;
        if (cur_i.pi < PI_LIM) begin
            up_o.pi = cur_i.pi + 1'b1;
        end else if (cur_i.tap < tap_top_i) begin
            up_o.pi  = '0;
            up_o.tap = cur_i.tap + 1'b1;
        end else if (cur_i.cd < CD_LIM) begin
            up_o.pi  = '0;
            up_o.tap = '0;
            up_o.cd  = cur_i.cd + 1'b1;
        end else if (cur_i.co < CO_LIM) begin
            up_o.pi  = '0;
            up_o.tap = '0;
            up_o.cd  = cur_i.cd - 1'b1;
            up_o.co  = cur_i.co + 1'b1;
        end else begin
            up_ok_o = 1'b0;
        end
    end

    // Earlier by one unit, the mirror of the above.
    always_comb begin
        dn_o    = cur_i;
        dn_ok_o = 1'b1;
        if (cur_i.pi != '0) begin
            dn_o.pi = cur_i.pi - 1'b1;
        end else if (cur_i.tap != '0) begin
            dn_o.pi  = PI_LIM;
            dn_o.tap = cur_i.tap - 1'b1;
        end else if (cur_i.cd != '0) begin
            dn_o.pi  = PI_LIM;
            dn_o.tap = tap_top_i;
            dn_o.cd  = cur_i.cd - 1'b1;
        end else if (cur_i.co != '0) begin
            dn_o.pi  = PI_LIM;
            dn_o.tap = tap_top_i;
            dn_o.cd  = cur_i.cd + 1'b1;
            dn_o.co  = cur_i.co - 1'b1;
        end else begin
            dn_ok_o = 1'b0;
        end
    end

endmodule

// File: rtl/dls_deadband.sv
module dls_deadband
    import dls_pkg::*;
(
    input  logic [TAP_W-1:0] tap_i,
    input  logic [PI_W-1:0]  pi_i,
    input  spd_lim_t         lim_i,
    output logic             en_o,
    output logic             sel_o
);

    logic below_lo;
    logic below_hi;

    assign below_lo = (tap_i < lim_i.t0) || ((tap_i == lim_i.t0) && (pi_i < lim_i.p0));
    assign below_hi = (tap_i < lim_i.t1) || ((tap_i == lim_i.t1) && (pi_i < lim_i.p1));

    always_comb begin
        if (below_lo) begin
            en_o  = 1'b1;
            sel_o = 1'b1;
        end else if (below_hi) begin
            en_o  = 1'b0;
            sel_o = 1'b0;
        end else begin
            en_o  = 1'b1;
            sel_o = 1'b0;
        end
    end

endmodule

// File: rtl/dll_code_stepper.sv
module dll_code_stepper
    import dls_pkg::*;
#(
    parameter int PI_TOP = 6,
    parameter int CD_TOP = 2,
    parameter int CO_TOP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       clk_sel_i,
    input  logic             step_up_i,
    input  logic             step_dn_i,
    input  logic             load_i,
    input  logic [CO_W-1:0]  load_coarse_i,
    input  logic [CD_W-1:0]  load_cdly_i,
    input  logic [TAP_W-1:0] load_tap_i,
    input  logic [PI_W-1:0]  load_pi_i,
    output logic [CO_W-1:0]  coarse_o,
    output logic [CD_W-1:0]  cdly_o,
    output logic [TAP_W-1:0] tap_o,
    output logic [PI_W-1:0]  pi_o,
    output logic             db_en_o,
    output logic             db_sel_o,
    output logic             done_o,
    output logic             err_o
);

    localparam logic [PI_W-1:0] PI_LIM = PI_W'(PI_TOP);
    localparam logic [CD_W-1:0] CD_LIM = CD_W'(CD_TOP);

    dly_code_t  code_q, up_code, dn_code, ld_code, cand;
    spd_lim_t   lim;
    logic       up_ok, dn_ok;
    logic       db_en_q, db_sel_q, db_en_n, db_sel_n;
    logic       step_req, step_ok;
    stp_state_t state_q, state_n;

    dls_speed_table u_table (
        .sel_i (clk_sel_i),
        .lim_o (lim)
    );

    dls_next_code #(
        .PI_TOP (PI_TOP),
        .CD_TOP (CD_TOP),
        .CO_TOP (CO_TOP)
    ) u_next (
        .cur_i     (code_q),
        .tap_top_i (lim.tap_top),
        .up_o      (up_code),
        .up_ok_o   (up_ok),
        .dn_o      (dn_code),
        .dn_ok_o   (dn_ok)
    );

    assign ld_code  = '{co: load_coarse_i, cd: load_cdly_i, tap: load_tap_i, pi: load_pi_i};
    assign step_req = step_up_i ^ step_dn_i;
    assign step_ok  = step_up_i ? up_ok : dn_ok;

    // Candidate code: load wins over a step.
    always_comb begin
        if (load_i) begin
            cand = ld_code;
        end else if (step_req && step_up_i) begin
            cand = up_code;
        end else if (step_req) begin
            cand = dn_code;
        end else begin
            cand = code_q;
        end
    end

    dls_deadband u_db (
        .tap_i (cand.tap),
        .pi_i  (cand.pi),
        .lim_i (lim),
        .en_o  (db_en_n),
        .sel_o (db_sel_n)
    );

    // Code and dead-band registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q   <= '0;
            db_en_q  <= 1'b1;
            db_sel_q <= 1'b1;
        end else if (load_i || (step_req && step_ok)) begin
            code_q   <= cand;
            db_en_q  <= db_en_n;
            db_sel_q <= db_sel_n;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Next state
    always_comb begin
        state_n = state_q;
        if (load_i) begin
            state_n = ST_IDLE;
        end else if (step_req) begin
            state_n = step_ok ? ST_STEPPED : ST_REFUSED;
        end else begin
            unique case (state_q)
                ST_IDLE:    state_n = ST_IDLE;
                ST_STEPPED: state_n = ST_IDLE;
                ST_REFUSED: state_n = ST_FAULT;
                ST_FAULT:   state_n = ST_FAULT;
            endcase
        end
    end

    // Outputs
    always_comb begin
        done_o = 1'b0;
        err_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_STEPPED: done_o = 1'b1;
            ST_REFUSED: begin
                done_o = 1'b1;
                err_o  = 1'b1;
            end
            ST_FAULT:   err_o = 1'b1;
        endcase
    end

    assign coarse_o = code_q.co;
    assign cdly_o   = code_q.cd;
    assign tap_o    = code_q.tap;
    assign pi_o     = code_q.pi;
    assign db_en_o  = db_en_q;
    assign db_sel_o = db_sel_q;

    // Assertions
    p_step_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && (step_up_i ^ step_dn_i)) |=> done_o);

    p_load_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (!done_o && !err_o));

    p_both_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && step_up_i && step_dn_i) |=> ($stable(code_q) && !done_o));

    p_refuse_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> ($stable(code_q) && $stable(db_en_q) && $stable(db_sel_q)));

    p_dbsel_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        db_sel_o |-> db_en_o);

    p_pi_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o && $past(step_up_i) && ($past(code_q.pi) < PI_LIM))
        |-> ((code_q.pi == $past(code_q.pi) + 1'b1) && (code_q.tap == $past(code_q.tap))));

    p_cd_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o && ($past(code_q.cd) <= CD_LIM)) |-> (code_q.cd <= CD_LIM));

endmodule

// File: tb/sim_dll_code_stepper.sv
module sim_dll_code_stepper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] clk_sel = 2'd0;
    logic       up = 1'b0, dn = 1'b0, ld = 1'b0;
    logic       ld_co = 1'b0;
    logic [1:0] ld_cd = '0;
    logic [3:0] ld_tap = '0;
    logic [2:0] ld_pi = '0;
    logic       coarse_o;
    logic [1:0] cdly_o;
    logic [3:0] tap_o;
    logic [2:0] pi_o;
    logic       db_en_o, db_sel_o, done_o, err_o;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    // model state
    int m_co = 0, m_cd = 0, m_tap = 0, m_pi = 0;
    int m_en = 1, m_sel = 1, m_done = 0, m_err = 0;
    bit m_ok;
    string m_tag;

    always #10 clk = ~clk;   // 50 MHz

    dll_code_stepper u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .clk_sel_i     (clk_sel),
        .step_up_i     (up),
        .step_dn_i     (dn),
        .load_i        (ld),
        .load_coarse_i (ld_co),
        .load_cdly_i   (ld_cd),
        .load_tap_i    (ld_tap),
        .load_pi_i     (ld_pi),
        .coarse_o      (coarse_o),
        .cdly_o        (cdly_o),
        .tap_o         (tap_o),
        .pi_o          (pi_o),
        .db_en_o       (db_en_o),
        .db_sel_o      (db_sel_o),
        .done_o        (done_o),
        .err_o         (err_o)
    );

    function automatic int tap_top(input int s);
        case (s)
            1: return 10;
            2: return 13;
            default: return 12;
        endcase
    endfunction

    task automatic db_model(input int s, input int tap, input int pi,
                            output int en, output int sl);
        int t0, p0, t1, p1;
        case (s)
            1: begin t0 = 2; p0 = 6; t1 = 8;  p1 = 7; end
            2: begin t0 = 3; p0 = 6; t1 = 11; p1 = 4; end
            default: begin t0 = 3; p0 = 2; t1 = 10; p1 = 3; end
        endcase
        if (tap < t0 || (tap == t0 && pi < p0)) begin en = 1; sl = 1; end
        else if (tap < t1 || (tap == t1 && pi < p1)) begin en = 0; sl = 0; end
        else begin en = 1; sl = 0; end
    endtask

    task automatic model_up(input int s);
        int tt = tap_top(s);
        m_ok = 1'b1;
        if (m_pi < 6) begin m_pi++; m_tag = "R2"; end
        else if (m_tap < tt) begin m_pi = 0; m_tap++; m_tag = "R3"; end
        else if (m_cd < 2) begin m_pi = 0; m_tap = 0; m_cd++; m_tag = "R4"; end
        else if (m_co < 1) begin m_pi = 0; m_tap = 0; m_cd--; m_co++; m_tag = "R4"; end
        else begin m_ok = 1'b0; m_tag = "R6"; end
    endtask

    task automatic model_dn(input int s);
        int tt = tap_top(s);
        m_ok = 1'b1;
        if (m_pi > 0) begin m_pi--; m_tag = "R2"; end
        else if (m_tap > 0) begin m_pi = 6; m_tap--; m_tag = "R5"; end
        else if (m_cd > 0) begin m_pi = 6; m_tap = tt; m_cd--; m_tag = "R5"; end
        else if (m_co > 0) begin m_pi = 6; m_tap = tt; m_cd++; m_co--; m_tag = "R5"; end
        else begin m_ok = 1'b0; m_tag = "R6"; end
    endtask

    task automatic check_vec(input string tag);
        logic [13:0] act, exp;
        act = {coarse_o, cdly_o, tap_o, pi_o, db_en_o, db_sel_o, done_o, err_o};
        exp = {m_co[0], m_cd[1:0], m_tap[3:0], m_pi[2:0], m_en[0], m_sel[0], m_done[0], m_err[0]};
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: co/cd/tap/pi/en/sel/done/err actual %0d/%0d/%0d/%0d/%0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d/%0d/%0d/%0d/%0d",
                     tag, act[13], act[12:11], act[10:7], act[6:4], act[3], act[2], act[1], act[0],
                     exp[13], exp[12:11], exp[10:7], exp[6:4], exp[3], exp[2], exp[1], exp[0]);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // kind: 0 idle, 1 up, 2 down, 3 both, 4 load, 5 load+up
    task automatic do_op(input int kind, input int lco, input int lcd, input int ltap,
                         input int lpi, input string tag_over);
        int s;
        string tag;
        up  = (kind == 1 || kind == 3 || kind == 5);
        dn  = (kind == 2 || kind == 3);
        ld  = (kind >= 4);
        ld_co = lco[0]; ld_cd = lcd[1:0]; ld_tap = ltap[3:0]; ld_pi = lpi[2:0];
        s = int'(clk_sel);
        @(negedge clk);
        if (kind >= 4) begin
            m_co = lco; m_cd = lcd; m_tap = ltap; m_pi = lpi;
            db_model(s, m_tap, m_pi, m_en, m_sel);
            m_done = 0; m_err = 0; tag = "R9";
        end else if (kind == 1 || kind == 2) begin
            if (kind == 1) model_up(s); else model_dn(s);
            tag = m_tag;
            m_done = 1;
            if (m_ok) begin
                m_err = 0;
                db_model(s, m_tap, m_pi, m_en, m_sel);
            end else begin
                m_err = 1;
            end
        end else begin
            m_done = 0;
            tag = (kind == 3) ? "R10" : "R8";
        end
        if (tag_over != "") tag = tag_over;
        check_vec(tag);
        up = 1'b0; dn = 1'b0; ld = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int r, s, co, cd, tp, p;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check_vec("R1");                 // during reset
        rst_n = 1'b1;
        @(negedge clk);
        check_vec("R1");                 // after release

        // full sweeps per clock setting
        for (int sv = 0; sv < 4; sv++) begin
            clk_sel = sv[1:0];
            do_op(4, 0, 0, 0, 0, "");
            n = 0;
            while (n < 1000) begin
                do_op(1, 0, 0, 0, 0, "");
                if (err_o) break;
                n++;
            end
            check_int("R4", n, 5 * (tap_top(sv) + 1) * 7 - 1);
            do_op(1, 0, 0, 0, 0, "R6");   // still refused at top
            do_op(0, 0, 0, 0, 0, "R6");   // error held, no done
            n = 0;
            while (n < 1000) begin
                do_op(2, 0, 0, 0, 0, "");
                if (err_o) break;
                n++;
            end
            check_int("R5", n, 5 * (tap_top(sv) + 1) * 7 - 1);
            do_op(1, 0, 0, 0, 0, "R6");   // accepted step clears error
        end

        // dead-band thresholds
        for (int sv = 0; sv < 3; sv++) begin
            clk_sel = sv[1:0];
            do_op(4, 0, 0, 3, 1, "R7");
            do_op(4, 0, 0, 3, 2, "R7");
            do_op(4, 0, 0, 2, 5, "R7");
            do_op(4, 0, 0, 2, 6, "R7");
            do_op(4, 0, 0, 10, 2, "R7");
            do_op(4, 0, 0, 10, 3, "R7");
            do_op(4, 0, 0, 11, 3, "R7");
            do_op(4, 0, 0, 11, 4, "R7");
            do_op(4, 0, 0, 8, 6, "R7");
            do_op(4, 1, 2, 9, 0, "R7");
        end

        // done strobe
        clk_sel = 2'd0;
        do_op(4, 0, 1, 5, 3, "R9");
        do_op(1, 0, 0, 0, 0, "R8");
        do_op(0, 0, 0, 0, 0, "R8");
        do_op(2, 0, 0, 0, 0, "R8");
        do_op(2, 0, 0, 0, 0, "R8");
        // load beats step
        do_op(5, 1, 0, 4, 6, "R9");
        do_op(4, 0, 0, 0, 0, "R9");
        do_op(2, 0, 0, 0, 0, "R6");
        do_op(5, 0, 2, 7, 2, "R9");   // load clears error
        // both directions together
        do_op(3, 0, 0, 0, 0, "R10");
        do_op(4, 0, 0, 0, 0, "R10");
        do_op(2, 0, 0, 0, 0, "R6");
        do_op(3, 0, 0, 0, 0, "R10");  // error kept
        // clock select change alone
        clk_sel = 2'd2;
        do_op(4, 0, 1, 3, 2, "R11");
        clk_sel = 2'd0;
        do_op(0, 0, 0, 0, 0, "R11");
        do_op(1, 0, 0, 0, 0, "R11");
        clk_sel = 2'd1;
        do_op(0, 0, 0, 0, 0, "R11");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            r = $urandom_range(0, 99);
            s = int'(clk_sel);
            if ($urandom_range(0, 1) == 1) begin
                co = 1; cd = 2; tp = tap_top(s) - $urandom_range(0, 1); p = $urandom_range(4, 6);
            end else begin
                co = $urandom_range(0, 1); cd = $urandom_range(0, 2);
                tp = $urandom_range(0, tap_top(s)); p = $urandom_range(0, 6);
            end
            if (r < 5)       do_op(4, co, cd, tp, p, "");
            else if (r < 8)  do_op(5, co, cd, tp, p, "R9");
            else if (r < 10) do_op(3, 0, 0, 0, 0, "R10");
            else if (r < 13) begin
                clk_sel = 2'($urandom_range(0, 3));
                do_op(0, 0, 0, 0, 0, "R11");
            end
            else if (r < 56) do_op(1, 0, 0, 0, 0, "");
            else             do_op(2, 0, 0, 0, 0, "");
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule